// File: doc/BRIEF.md
# Multi-Policy Shared-Bus Arbiter

This block decides which of N masters owns a pipelined shared system bus. Each master raises a request line and receives a one-hot grant. The arbiter observes the slave ready signal and the transfer type and burst code of the current address phase. From these it knows when a transfer completes and whether a fixed-length burst still has beats to issue. Ownership moves only on a ready edge. It also moves only at a burst boundary, with one exception: a reserved window may cut a burst short, and the interrupted master rebuilds the rest of its burst later. When a handover is allowed, the new master drives its address in the very next cycle.

Three contention policies are selected at run time. Rotating priority serves requesters fairly. Time-division mode gives each time slot to a master named in a configuration table, and a slot whose owner is idle falls back to rotating priority. Reservation mode opens a periodic window in which only one designated master may hold the bus, and uses rotating priority outside that window. The arbiter also reports which master owns the address phase and which owns the data phase. The data-phase owner trails the address-phase owner by one completed transfer.

Top module: `arb_multi_policy`

## Requirements
- R1: After reset the grant is on master 0 (grant_o = 1), and the address and data owners both read 0.
- R2: grant_o always has exactly one bit set.
- R3: grant_o changes only on a clock edge at which hready_i is high. While hready_i is low, the grant, the owners and the burst state hold.
- R4: On every edge with hready_i high, addr_owner_o takes the index of the master granted before that edge, and data_owner_o takes the previous addr_owner_o.
- R5: Transfer types are 0 idle, 1 busy, 2 non-sequential and 3 sequential. Burst codes are 0 single, 1 undefined-length, 2/3 four beats, 4/5 eight beats and 6/7 sixteen beats. Once the first beat of a fixed-length burst is accepted, the grant holds until the edge that accepts its last sequential beat. Busy cycles do not count as beats. The only exception is R11.
- R6: A single transfer or an undefined-length burst permits a handover on any edge that accepts a beat.
- R7: Under rotating priority (mode_i 0, and also 3), a handover picks the first requesting master after the last master that was granted while requesting, wrapping past N-1. Idle masters are skipped.
- R8: When no master requests at a handover edge, and no reserved window is in force, the grant parks on master 0.
- R9: In time-division mode (mode_i 1), a slot counter advances every cycle and wraps after tdma_len_i cycles (a value of 0 acts as 1). The slot index then steps through TBL_DEPTH entries. Entry k is tdma_tbl_i[k*IDX_W +: IDX_W], and that master is granted at a handover edge if it requests. Both counters start at 0 at reset and run in every mode.
- R10: In time-division mode, a slot whose owner does not request goes to the next requester by rotating priority.
- R11: In reservation mode (mode_i 2), a free-running period counter wraps after rsv_period_i cycles (0 acts as 1), and the window is open while its count is below rsv_len_i. On any edge with hready_i high inside the window, the grant moves to rsv_master_i, cutting a burst short if needed.
- R12: In reservation mode outside the window, rotating priority applies, and a burst of the reserved master that spans the window end is not interrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Policy: 0 rotating, 1 time-division, 2 reservation, 3 rotating |
| req_i | input | N_MST | Request line per master |
| hready_i | input | 1 | Slave ready; a transfer completes on an edge where it is high |
| htrans_i | input | 2 | Transfer type of the current address phase |
| hburst_i | input | 3 | Burst code of the current address phase |
| tdma_len_i | input | SLOT_W | Time-division slot length in cycles |
| tdma_tbl_i | input | TBL_DEPTH*IDX_W | Slot-to-master table, entry k in bits [k*IDX_W +: IDX_W] |
| rsv_period_i | input | PER_W | Reservation period in cycles |
| rsv_len_i | input | PER_W | Reserved window length in cycles |
| rsv_master_i | input | IDX_W | Master that owns the reserved window |
| grant_o | output | N_MST | One-hot grant |
| addr_owner_o | output | IDX_W | Master owning the current address phase |
| data_owner_o | output | IDX_W | Master owning the current data phase |

## Verification
The assertions assume that the masters follow the transfer protocol. A sequential beat appears only while a fixed-length burst still has beats to issue, and a granted master starts every new burst with a non-sequential beat, including a burst it restarts after being cut short. The stimulus enforces this by generating transfer types from the bench's own count of outstanding beats. It issues sequential or busy cycles while that count is nonzero, and idle or non-sequential cycles with a random burst code otherwise. Requests, ready and configuration are otherwise random, with fixed seeds and directed sequences for parking, a full sixteen-beat burst, a stalled bus and undefined-length handover.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int BEAT_W = 4;

  localparam logic [1:0] MODE_RR   = 2'd0;
  localparam logic [1:0] MODE_TDMA = 2'd1;
  localparam logic [1:0] MODE_RSV  = 2'd2;

  typedef enum logic [1:0] {
    TR_IDLE = 2'd0,
    TR_BUSY = 2'd1,
    TR_NSEQ = 2'd2,
    TR_SEQ  = 2'd3
  } trans_e;

  // beats still to issue after the first beat of a burst
  function automatic logic [BEAT_W-1:0] burst_extra(input logic [2:0] code);
    case (code[2:1])
      2'd1:    burst_extra = BEAT_W'(3);
      2'd2:    burst_extra = BEAT_W'(7);
      2'd3:    burst_extra = BEAT_W'(15);
      default: burst_extra = '0;
    endcase
  endfunction
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_MST = 4,
  localparam int IDX_W = $clog2(N_MST)
) (
  input  logic [N_MST-1:0] req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] pick_o,
  output logic             found_o
);
  always_comb begin
    pick_o  = '0;
    found_o = 1'b0;
    for (int k = 1; k <= N_MST; k++) begin
      int t;
      t = int'(last_i) + k;
      if (t >= N_MST) t = t - N_MST;
      if (!found_o && req_i[t]) begin
        found_o = 1'b1;
        pick_o  = IDX_W'(t);
      end
    end
  end
endmodule

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
  parameter int SLOT_W    = 8,
  parameter int PER_W     = 8,
  parameter int TBL_DEPTH = 4,
  localparam int SIDX_W   = $clog2(TBL_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] tdma_len_i,
  input  logic [PER_W-1:0]  rsv_period_i,
  input  logic [PER_W-1:0]  rsv_len_i,
  output logic [SIDX_W-1:0] slot_idx_o,
  output logic              rsv_win_o
);
  logic [SLOT_W-1:0] cnt_q;
  logic [PER_W-1:0]  per_q;
  logic [SIDX_W-1:0] sidx_q;
  logic [SLOT_W:0]   cnt_inc;
  logic [PER_W:0]    per_inc;

  assign cnt_inc    = {1'b0, cnt_q} + 1'b1;
  assign per_inc    = {1'b0, per_q} + 1'b1;
  assign slot_idx_o = sidx_q;
  assign rsv_win_o  = per_q < rsv_len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sidx_q <= '0;
      per_q  <= '0;
    end else begin
      if (cnt_inc >= {1'b0, tdma_len_i}) begin
        cnt_q  <= '0;
        sidx_q <= (sidx_q == SIDX_W'(TBL_DEPTH-1)) ? '0 : sidx_q + 1'b1;
      end else begin
        cnt_q <= cnt_inc[SLOT_W-1:0];
      end
      per_q <= (per_inc >= {1'b0, rsv_period_i}) ? '0 : per_inc[PER_W-1:0];
    end
  end
endmodule

// File: rtl/arb_beat_tracker.sv
module arb_beat_tracker
  import arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hready_i,
  input  logic [1:0]        htrans_i,
  input  logic [2:0]        hburst_i,
  input  logic              clear_i,
  output logic [BEAT_W-1:0] beats_next_o
);
  logic [BEAT_W-1:0] beats_q;

  always_comb begin
    case (trans_e'(htrans_i))
      TR_NSEQ: beats_next_o = burst_extra(hburst_i);
      TR_SEQ:  beats_next_o = (beats_q != '0) ? beats_q - 1'b1 : '0;
      TR_BUSY: beats_next_o = beats_q;
      default: beats_next_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       beats_q <= '0;
    else if (hready_i) beats_q <= clear_i ? '0 : beats_next_o;
  end

  // R3
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |=> $stable(beats_q));
endmodule

// File: rtl/arb_multi_policy.sv
module arb_multi_policy
  import arb_pkg::*;
#(
  parameter int N_MST     = 4,
  parameter int TBL_DEPTH = 4,
  parameter int SLOT_W    = 8,
  parameter int PER_W     = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [1:0]                           mode_i,
  input  logic [N_MST-1:0]                     req_i,
  input  logic                                 hready_i,
  input  logic [1:0]                           htrans_i,
  input  logic [2:0]                           hburst_i,
  input  logic [SLOT_W-1:0]                    tdma_len_i,
  input  logic [TBL_DEPTH*$clog2(N_MST)-1:0]   tdma_tbl_i,
  input  logic [PER_W-1:0]                     rsv_period_i,
  input  logic [PER_W-1:0]                     rsv_len_i,
  input  logic [$clog2(N_MST)-1:0]             rsv_master_i,
  output logic [N_MST-1:0]                     grant_o,
  output logic [$clog2(N_MST)-1:0]             addr_owner_o,
  output logic [$clog2(N_MST)-1:0]             data_owner_o
);
  localparam int IDX_W  = $clog2(N_MST);
  localparam int SIDX_W = $clog2(TBL_DEPTH);

  logic [IDX_W-1:0]  gnt_q, last_q, ao_q, do_q;
  logic [IDX_W-1:0]  nxt, rr_pick, slot_owner;
  logic [SIDX_W-1:0] slot_idx;
  logic [BEAT_W-1:0] beats_next;
  logic              rr_found, win, rsv_lock, preempt, allow, hand;

  arb_slot_timer #(.SLOT_W(SLOT_W), .PER_W(PER_W), .TBL_DEPTH(TBL_DEPTH)) u_timer (
    .clk_i, .rst_ni, .tdma_len_i, .rsv_period_i, .rsv_len_i,
    .slot_idx_o(slot_idx), .rsv_win_o(win)
  );

  arb_beat_tracker u_beats (
    .clk_i, .rst_ni, .hready_i, .htrans_i, .hburst_i,
    .clear_i(hand), .beats_next_o(beats_next)
  );

  arb_rr_pick #(.N_MST(N_MST)) u_rr (
    .req_i, .last_i(last_q), .pick_o(rr_pick), .found_o(rr_found)
  );

  assign slot_owner = tdma_tbl_i[slot_idx*IDX_W +: IDX_W];
  assign rsv_lock   = (mode_i == MODE_RSV) && win;
  assign preempt    = rsv_lock && (gnt_q != rsv_master_i);
  assign allow      = hready_i && ((beats_next == '0) || preempt);
  assign hand       = allow && (nxt != gnt_q);

  always_comb begin
    if (rsv_lock)                                      nxt = rsv_master_i;
    else if (mode_i == MODE_TDMA && req_i[slot_owner]) nxt = slot_owner;
    else if (rr_found)                                 nxt = rr_pick;
    else                                               nxt = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      last_q <= IDX_W'(N_MST-1);
      ao_q   <= '0;
      do_q   <= '0;
    end else begin
      if (hready_i) begin
        ao_q <= gnt_q;
        do_q <= ao_q;
      end
      if (allow) begin
        gnt_q <= nxt;
        if (req_i[nxt]) last_q <= nxt;
      end
    end
  end

  for (genvar g = 0; g < N_MST; g++) begin : g_gnt
    assign grant_o[g] = (gnt_q == IDX_W'(g));
  end
  assign addr_owner_o = ao_q;
  assign data_owner_o = do_q;

  // R2
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) == 1);
  // R3
  gnt_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |=> $stable(grant_o));
  // R5
  burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hready_i && beats_next != '0 && !preempt |=> $stable(grant_o));
  // R8
  park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hready_i && beats_next == '0 && req_i == '0 && !rsv_lock
    |=> grant_o == N_MST'(1));
  // R11
  rsv_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_lock && hready_i |=> grant_o[$past(rsv_master_i)]);
endmodule

// File: tb/arb_multi_policy_tb.sv
`timescale 1ns/1ps
module arb_multi_policy_tb;
  localparam int N   = 4;
  localparam int TBL = 4;
  localparam int IW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [N-1:0]  req = '0;
  logic          hready = 1'b1;
  logic [1:0]    htrans = 2'd0;
  logic [2:0]    hburst = 3'd0;
  logic [7:0]    tdma_len = 8'd3;
  logic [TBL*IW-1:0] tdma_tbl = 8'b10_00_01_11;
  logic [7:0]    rsv_period = 8'd20;
  logic [7:0]    rsv_len = 8'd0;
  logic [IW-1:0] rsv_m = 2'd3;
  logic [N-1:0]  grant;
  logic [IW-1:0] ao, dov;

  int checks = 0, errors = 0;
  int m_gnt, m_last, m_ao, m_do, m_beats, m_cnt, m_sidx, m_pcnt;

  always #2.5 clk = ~clk;

  arb_multi_policy u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .req_i(req), .hready_i(hready),
    .htrans_i(htrans), .hburst_i(hburst), .tdma_len_i(tdma_len), .tdma_tbl_i(tdma_tbl),
    .rsv_period_i(rsv_period), .rsv_len_i(rsv_len), .rsv_master_i(rsv_m),
    .grant_o(grant), .addr_owner_o(ao), .data_owner_o(dov)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int extra(input int code);
    case (code / 2)
      1: return 3;
      2: return 7;
      3: return 15;
      default: return 0;
    endcase
  endfunction

  // reference model, advanced once per rising edge with the inputs then applied
  task automatic model_step();
    int bn, nxt, t;
    bit win, lock, allow, found;
    case (htrans)
      2'd2: bn = extra(hburst);
      2'd3: bn = (m_beats > 0) ? m_beats - 1 : 0;
      2'd1: bn = m_beats;
      default: bn = 0;
    endcase
    win   = m_pcnt < rsv_len;
    lock  = (mode == 2'd2) && win;
    allow = hready && (bn == 0 || (lock && m_gnt != rsv_m));
    found = 0;
    nxt   = 0;
    if (lock) nxt = rsv_m;
    else if (mode == 2'd1 && req[tdma_tbl[m_sidx*IW +: IW]]) nxt = tdma_tbl[m_sidx*IW +: IW];
    else begin
      for (int k = 1; k <= N; k++) begin
        t = (m_last + k) % N;
        if (!found && req[t]) begin found = 1; nxt = t; end
      end
    end
    if (hready) begin
      m_do    = m_ao;
      m_ao    = m_gnt;
      m_beats = (allow && nxt != m_gnt) ? 0 : bn;
    end
    if (allow) begin
      if (req[nxt]) m_last = nxt;
      m_gnt = nxt;
    end
    if (m_cnt + 1 >= tdma_len) begin
      m_cnt  = 0;
      m_sidx = (m_sidx + 1) % TBL;
    end else m_cnt++;
    m_pcnt = (m_pcnt + 1 >= rsv_period) ? 0 : m_pcnt + 1;
  endtask

  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    chk(tag, grant, 1 << m_gnt);
    chk("R2", $countones(grant), 1);
    chk("R4", ao, m_ao);
    chk("R4", dov, m_do);
  endtask

  task automatic rand_phase(input string tag, input int cycles, input int dense);
    for (int i = 0; i < cycles; i++) begin
      req    = N'($urandom);
      if (!dense) req = req & N'($urandom) & N'($urandom);
      hready = ($urandom % 4) != 0;
      if (m_beats > 0) htrans = (($urandom % 5) == 0) ? 2'd1 : 2'd3;
      else begin
        htrans = (($urandom % 3) == 0) ? 2'd0 : 2'd2;
        hburst = 3'($urandom);
      end
      tick(tag);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_gnt = 0; m_last = N - 1; m_ao = 0; m_do = 0;
    m_beats = 0; m_cnt = 0; m_sidx = 0; m_pcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1", grant, 1);
    chk("R1", ao, 0);
    chk("R1", dov, 0);

    // R8 park with no requests
    req = '0; hready = 1'b1; htrans = 2'd0;
    repeat (3) tick("R8");
    chk("R8", grant, 1);

    // R5 sixteen-beat burst by master 1 while master 2 waits
    req = 4'b0010;
    tick("R5");
    chk("R5", grant, 4'b0010);
    req = 4'b0110; htrans = 2'd2; hburst = 3'd7;
    tick("R5");
    chk("R5", grant, 4'b0010);
    htrans = 2'd3;
    for (int b = 0; b < 14; b++) begin
      tick("R5");
      chk("R5", grant, 4'b0010);
    end
    tick("R5");
    chk("R5", grant, 4'b0100);

    // R3 stalled bus holds the grant
    htrans = 2'd0; hready = 1'b0; req = 4'b1000;
    for (int s = 0; s < 5; s++) begin
      tick("R3");
      chk("R3", grant, 4'b0100);
    end
    hready = 1'b1;
    tick("R3");
    chk("R3", grant, 4'b1000);

    // R6 undefined-length burst yields at the next accepted beat
    req = 4'b1001; htrans = 2'd2; hburst = 3'd1;
    tick("R6");
    chk("R6", grant, 4'b0001);
    htrans = 2'd3;
    tick("R6");
    chk("R6", grant, 4'b1000);

    mode = 2'd0;
    rand_phase("R7", 400, 1);
    rand_phase("R8", 100, 0);

    mode = 2'd1; tdma_len = 8'd3;
    rand_phase("R9", 400, 1);
    tdma_len = 8'd0;
    rand_phase("R9", 100, 1);
    tdma_len = 8'd5;
    rand_phase("R10", 400, 0);

    mode = 2'd2; rsv_period = 8'd20; rsv_len = 8'd5; rsv_m = 2'd3;
    rand_phase("R11", 500, 1);
    rsv_m = 2'd1; rsv_len = 8'd2; rsv_period = 8'd9;
    rand_phase("R11", 300, 0);
    rsv_len = 8'd0;
    rand_phase("R12", 300, 1);
    rsv_len = 8'd4; rsv_period = 8'd30;
    rand_phase("R12", 300, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule